// File: doc/BRIEF.md
# Keyed watchdog timer

A free-running watchdog whose configuration can only be changed after a two-step key handshake. Software writes the first key to one key address and the second key to another. That opens exactly one write to a guarded register. Any deviation closes the lock again.

The guarded registers are:
- a limit register, which sets the expiry count;
- a two-bit control register, where bit 0 runs the counter and bit 1 allows reset generation;
- a status register;
- an acknowledge register;
- the counter address. A guarded write there restarts the count, which services the watchdog.

When the running counter equals the limit, the block does four things:
- it wraps the counter to zero;
- it sets a sticky expiry status;
- it raises a reset request for a fixed number of cycles, if reset generation is allowed;
- it leaves any reset pulse already in progress unchanged. That pulse is not extended.

A clock and reset controller outside the block consumes the request.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the limit reads all ones, control reads 0, status reads 0, the counter reads 0, and rst_req and expired are low.
- R2: A write of 0xBABA to address 0 followed by a write of 0xEB10 to address 1 enables the next bus write. If that write targets address 2 (limit), 3 (control, bits 1:0), 4 (status), 5 (acknowledge) or 6 (counter), it takes effect on the following cycle.
- R3: The unlock is consumed by the next bus write of any kind. A second guarded write needs the full key sequence again.
- R4: A wrong key value, the keys in reverse order, or any other bus write between the two keys returns the lock to closed. A guarded write that follows is ignored.
- R5: A guarded write with no preceding key sequence leaves the register unchanged.
- R6: While control bit 0 is set, the counter at address 6 increases by one per cycle. While control bit 0 is clear, the counter holds its value.
- R7: When control bit 0 is set and the counter equals the limit, the counter reads 0 on the next cycle, and status bit 0 (address 4) and the expired output go high.
- R8: If control bit 1 is also set at that match, rst_req goes high on the next cycle and stays high for exactly 16 cycles. A match during the pulse neither extends it nor restarts it.
- R9: With control bit 1 clear, a match sets status but rst_req stays low.
- R10: Status is sticky. Only an unlocked write to address 4 with bit 0 = 0, or an unlocked write to address 5 with bit 0 = 1, clears it. A match in the same cycle as a clear keeps it set.
- R11: An unlocked write of any value to address 6 sets the counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| addr | input | 3 | Register address for writes and reads |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (limit, control, status, counter; others read 0) |
| rst_req | output | 1 | Reset request pulse to the system reset controller |
| expired | output | 1 | Sticky expiry status |

## Verification
The bench attacks the lock with three kinds of broken sequence:
- a wrong first key;
- the keys swapped;
- an unrelated write wedged between the two keys.

It also tries a second guarded write that reuses a spent unlock. A lock that forgot to close would let the limit change in those cases.

The expiry path is run with a limit shorter than the reset pulse, so that a match lands inside an active pulse. A design that restarts the pulse there would hold reset high for good.

The bench also checks three status cases:
- status survives a wrong-polarity clear;
- status survives a locked clear;
- with reset generation disabled, the output stays quiet after a match.

A behavioural model shadows every register and is compared with the outputs on every cycle.

// File: rtl/keyed_watchdog_pkg.sv
package keyed_watchdog_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_KEY1  = 3'd0;
    localparam logic [ADDR_W-1:0] A_KEY2  = 3'd1;
    localparam logic [ADDR_W-1:0] A_LIMIT = 3'd2;
    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_ACK   = 3'd5;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd6;

    localparam int CTRL_W   = 2;
    localparam int CTRL_RUN = 0;
    localparam int CTRL_RST = 1;

    typedef enum logic [1:0] {
        LK_SHUT = 2'd0,
        LK_HALF = 2'd1,
        LK_OPEN = 2'd2
    } lock_e;

endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
    import keyed_watchdog_pkg::*;
#(
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY1   = 32'h0000_BABA,
    parameter logic [DATA_W-1:0] KEY2   = 32'h0000_EB10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              grant
);

    typedef struct packed {
        lock_e st;
    } lock_t;

    lock_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (wr_en) begin
            unique case (lk_q.st)
                LK_SHUT: lk_d.st = (addr == A_KEY1 && wdata == KEY1) ? LK_HALF : LK_SHUT;
                LK_HALF: lk_d.st = (addr == A_KEY2 && wdata == KEY2) ? LK_OPEN : LK_SHUT;
                default: lk_d.st = LK_SHUT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '{st: LK_SHUT};
        else        lk_q <= lk_d;
    end

    assign grant = wr_en && (lk_q.st == LK_OPEN);

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import keyed_watchdog_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              limit_we,
    input  logic [CNT_W-1:0]  limit_in,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_in,
    input  logic              stat_clr,
    input  logic              kick,
    output logic [CNT_W-1:0]  limit,
    output logic [CTRL_W-1:0] ctrl,
    output logic [CNT_W-1:0]  count,
    output logic              status,
    output logic              rst_req
);

    localparam int PW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  limit;
        logic [CTRL_W-1:0] ctrl;
        logic [CNT_W-1:0]  count;
        logic              status;
        logic [PW-1:0]     pulse;
    } core_t;

    core_t c_d, c_q;
    logic  hit;

    always_comb begin
        c_d = c_q;
        hit = c_q.ctrl[CTRL_RUN] && (c_q.count == c_q.limit);

        if (c_q.ctrl[CTRL_RUN]) c_d.count = c_q.count + CNT_W'(1);
        if (hit || kick)        c_d.count = '0;

        if (stat_clr) c_d.status = 1'b0;
        if (hit)      c_d.status = 1'b1;

        if (c_q.pulse != '0)                c_d.pulse = c_q.pulse - PW'(1);
        else if (hit && c_q.ctrl[CTRL_RST]) c_d.pulse = PW'(PULSE_LEN);

        if (limit_we) c_d.limit = limit_in;
        if (ctrl_we)  c_d.ctrl  = ctrl_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.limit  <= '1;
            c_q.ctrl   <= '0;
            c_q.count  <= '0;
            c_q.status <= 1'b0;
            c_q.pulse  <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign limit   = c_q.limit;
    assign ctrl    = c_q.ctrl;
    assign count   = c_q.count;
    assign status  = c_q.status;
    assign rst_req = (c_q.pulse != '0);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import keyed_watchdog_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                CNT_W     = 32,
    parameter int                PULSE_LEN = 16,
    parameter logic [DATA_W-1:0] KEY1      = 32'h0000_BABA,
    parameter logic [DATA_W-1:0] KEY2      = 32'h0000_EB10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_req,
    output logic              expired
);

    logic              grant;
    logic [CNT_W-1:0]  limit_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  count_q;
    logic              limit_we, ctrl_we, stat_clr, kick;

    wdt_unlock #(.DATA_W(DATA_W), .KEY1(KEY1), .KEY2(KEY2)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .grant (grant)
    );

    always_comb begin
        limit_we = grant && (addr == A_LIMIT);
        ctrl_we  = grant && (addr == A_CTRL);
        kick     = grant && (addr == A_COUNT);
        stat_clr = grant && (((addr == A_STAT) && !wdata[0]) ||
                             ((addr == A_ACK)  &&  wdata[0]));
    end

    wdt_core #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .limit_we (limit_we),
        .limit_in (wdata[CNT_W-1:0]),
        .ctrl_we  (ctrl_we),
        .ctrl_in  (wdata[CTRL_W-1:0]),
        .stat_clr (stat_clr),
        .kick     (kick),
        .limit    (limit_q),
        .ctrl     (ctrl_q),
        .count    (count_q),
        .status   (expired),
        .rst_req  (rst_req)
    );

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_LIMIT: rdata = DATA_W'(limit_q);
            A_CTRL:  rdata = DATA_W'(ctrl_q);
            A_STAT:  rdata = DATA_W'(expired);
            A_COUNT: rdata = DATA_W'(count_q);
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk
    import keyed_watchdog_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int PULSE_LEN = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [2:0]        addr,
    input logic              grant,
    input logic [CNT_W-1:0]  limit,
    input logic [CTRL_W-1:0] ctrl,
    input logic              status,
    input logic              rst_req
);

    localparam int RW = $clog2(PULSE_LEN + 2) + 1;

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                run_q <= '0;
        else if (!rst_req)         run_q <= '0;
        else if (run_q != '1)      run_q <= run_q + RW'(1);
    end

    // R8
    pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> run_q < RW'(PULSE_LEN));

    // R8
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> run_q == RW'(PULSE_LEN));

    // R9
    rst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(ctrl[CTRL_RST]));

    // R7
    stat_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> status);

    // R5
    locked_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_LIMIT && !grant) |=> $stable(limit));

    // R10
    sticky_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status) |-> $past(grant));

    // R3
    single_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !grant);

endmodule

bind keyed_watchdog keyed_watchdog_chk #(.CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .grant   (grant),
    .limit   (limit_q),
    .ctrl    (ctrl_q),
    .status  (expired),
    .rst_req (rst_req)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        rst_req, expired;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    keyed_watchdog u_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rst_req(rst_req), .expired(expired)
    );

    // behavioural reference model
    logic [31:0] m_limit, m_cnt;
    logic [1:0]  m_ctrl;
    logic        m_stat;
    int          m_pulse, m_lk;

    always @(posedge clk or negedge rst_n) begin
        bit g, mt;
        if (!rst_n) begin
            m_limit = 32'hFFFF_FFFF; m_cnt = 0; m_ctrl = 0; m_stat = 0;
            m_pulse = 0; m_lk = 0;
        end else begin
            g  = wr_en && (m_lk == 2);
            mt = m_ctrl[0] && (m_cnt == m_limit);
            if (m_pulse != 0) m_pulse = m_pulse - 1;
            else if (mt && m_ctrl[1]) m_pulse = 16;
            if (g && addr == 6) m_cnt = 0;
            else if (mt) m_cnt = 0;
            else if (m_ctrl[0]) m_cnt = m_cnt + 1;
            if (mt) m_stat = 1;
            else if (g && addr == 4 && !wdata[0]) m_stat = 0;
            else if (g && addr == 5 && wdata[0]) m_stat = 0;
            if (g && addr == 2) m_limit = wdata;
            if (g && addr == 3) m_ctrl = wdata[1:0];
            if (wr_en) begin
                if (m_lk == 0) m_lk = (addr == 0 && wdata == 32'hBABA) ? 1 : 0;
                else if (m_lk == 1) m_lk = (addr == 1 && wdata == 32'hEB10) ? 2 : 0;
                else m_lk = 0;
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd2: return m_limit;
            3'd3: return {30'd0, m_ctrl};
            3'd4: return {31'd0, m_stat};
            3'd6: return m_cnt;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check({31'd0, rst_req}, {31'd0, m_pulse != 0}, "R8 model rst_req");
            check({31'd0, expired}, {31'd0, m_stat}, "R7 model expired");
            check(rdata, m_read(addr), "R6 model rdata");
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(3'd0, 32'hBABA);
        wr(3'd1, 32'hEB10);
    endtask

    task automatic pwr(input logic [2:0] a, input logic [31:0] d);
        unlock();
        wr(a, d);
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        addr = a; wr_en = 1'b0;
        @(negedge clk);
        check(rdata, exp, tag);
        @(posedge clk); #2;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog timeout actual=%0d expected<100000", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] v1, v2, prev;
        int hi, run, seen;
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check({31'd0, rst_req}, 0, "R1 rst_req");
        check({31'd0, expired}, 0, "R1 expired");
        @(posedge clk); #2;
        rd_chk(3'd2, 32'hFFFF_FFFF, "R1 limit");
        rd_chk(3'd3, 0, "R1 ctrl");
        rd_chk(3'd4, 0, "R1 status");
        rd_chk(3'd6, 0, "R1 count");

        // R5 locked write ignored
        wr(3'd2, 32'h20);
        rd_chk(3'd2, 32'hFFFF_FFFF, "R5 limit unchanged");

        // R2 unlock then write
        pwr(3'd2, 32'h20);
        rd_chk(3'd2, 32'h20, "R2 limit written");
        // R3 spent unlock
        wr(3'd2, 32'h30);
        rd_chk(3'd2, 32'h20, "R3 second write ignored");
        unlock(); wr(3'd7, 0); wr(3'd2, 32'h31);
        rd_chk(3'd2, 32'h20, "R3 unlock consumed by other write");

        // R4 broken sequences
        wr(3'd0, 32'h1234); wr(3'd1, 32'hEB10); wr(3'd2, 32'h40);
        rd_chk(3'd2, 32'h20, "R4 wrong key");
        wr(3'd1, 32'hEB10); wr(3'd0, 32'hBABA); wr(3'd2, 32'h41);
        rd_chk(3'd2, 32'h20, "R4 reversed keys");
        wr(3'd0, 32'hBABA); wr(3'd7, 32'h5); wr(3'd1, 32'hEB10); wr(3'd2, 32'h42);
        rd_chk(3'd2, 32'h20, "R4 intervening write");

        // R9 match without reset generation
        pwr(3'd2, 32'hF);
        pwr(3'd3, 32'h1);
        seen = 0; hi = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (expired) seen = 1;
            if (rst_req) hi++;
        end
        @(posedge clk); #2;
        check(seen, 1, "R7 status set on match");
        check(hi, 0, "R9 no rst_req with bit1 clear");
        pwr(3'd3, 32'h0);

        // R10 sticky status and clear polarity
        idle(5);
        rd_chk(3'd4, 1, "R10 status sticky");
        wr(3'd4, 32'h0);
        rd_chk(3'd4, 1, "R10 locked clear ignored");
        pwr(3'd4, 32'h1);
        rd_chk(3'd4, 1, "R10 bit0=1 to status keeps it");
        pwr(3'd4, 32'h0);
        rd_chk(3'd4, 0, "R10 status cleared");

        // R6 counting / holding, R11 kick
        pwr(3'd2, 32'd100);
        pwr(3'd6, 32'h0);
        pwr(3'd3, 32'h1);
        idle(10);
        pwr(3'd3, 32'h0);
        addr = 3'd6; @(negedge clk); v1 = rdata;
        idle(6);
        @(negedge clk); v2 = rdata;
        @(posedge clk); #2;
        check({31'd0, v1 > 10 && v1 < 30}, 1, "R6 counted while enabled");
        check(v2, v1, "R6 held while disabled");
        pwr(3'd6, 32'h1234);
        rd_chk(3'd6, 0, "R11 kick clears counter");

        // R7 wrap at limit
        pwr(3'd2, 32'd3);
        pwr(3'd3, 32'h1);
        addr = 3'd6;
        @(negedge clk); prev = rdata;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check({31'd0, rdata <= 3}, 1, "R7 count bounded by limit");
            check(rdata, (prev == 3) ? 0 : prev + 1, "R7 wrap sequence");
            prev = rdata;
        end
        @(posedge clk); #2;
        pwr(3'd3, 32'h0);
        rd_chk(3'd4, 1, "R7 status after wrap");
        pwr(3'd5, 32'h0);
        rd_chk(3'd4, 1, "R10 ack bit0=0 keeps status");
        pwr(3'd5, 32'h1);
        rd_chk(3'd4, 0, "R10 ack clears status");

        // R8 reset pulse length, match during pulse
        pwr(3'd6, 32'h0);
        pwr(3'd2, 32'hF);
        pwr(3'd3, 32'h3);
        for (int p = 0; p < 2; p++) begin
            run = 0;
            for (int i = 0; i < 200 && !rst_req; i++) @(negedge clk);
            while (rst_req && run < 100) begin
                run++;
                @(negedge clk);
            end
            check(run, 16, "R8 pulse width");
        end
        @(posedge clk); #2;
        pwr(3'd3, 32'h0);
        pwr(3'd5, 32'h1);
        rd_chk(3'd4, 0, "R10 final clear");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule